// File: doc/BRIEF.md
# Stack Frame Push/Pop Sequencer

This block runs the compressed stack-frame instructions of a small 32-bit core: push a group of callee-saved registers plus the return address, pop them back, pop and return, pop and return with a zeroed result register, and the two paired moves between the argument registers a0/a1 and two chosen saved registers. The core hands it one 16-bit instruction with a start pulse. The block then owns the register-file port and a valid/ready memory port until it raises done.

A push or pop first reads the stack pointer (x2). It then moves one register per accepted memory transfer, starting with the highest-numbered register in the selected set and moving 4 bytes lower each time. It finishes by writing the adjusted stack pointer and, for the return forms, the program counter. Every transfer address is derived from the stack pointer as it was before the instruction. The paired moves use no memory and take two register-file cycles.

Top module: `stack_seq`

## Requirements
- R1: Recognised encodings all have bits 1:0 = 2'b10. Push has bits 15:8 = 8'hB8. Pop has 8'hBA, pop-return-zero has 8'hBC, and pop-return has 8'hBE. The moves have bits 15:10 = 6'b101011, with bits 6:5 = 2'b01 for a0/a1 to s-registers and 2'b11 for s-registers to a0/a1. Any other value, and any push or pop whose bits 7:4 are below 4, makes no memory access and no register or PC write, and raises done in the cycle after start.
- R2: Bits 7:4 (value v) select 13 registers when v = 15 and v-3 registers otherwise. Exactly that many memory transfers are accepted.
- R3: In ascending order the selectable registers are x1, x8, x9, x18..x27, and a list of n takes the first n. Transfers walk this set from the highest register down, so the first transfer handles the last register in the set.
- R4: The adjustment is a base plus 16 times bits 3:2. The base is 16 for up to 4 registers, 32 for up to 8, 48 for up to 12, and 64 for 13.
- R5: Push stores each register at sp-4, sp-8, and so on, in walk order, and then writes sp-adj to x2.
- R6: Pop loads each register from sp+adj-4, sp+adj-8, and so on, in walk order, and then writes sp+adj to x2.
- R7: The pop-return forms set the PC to the reloaded x1, in the same cycle as the stack-pointer write. Pop-return-zero afterwards writes 0 to x10. Plain pop and push never write the PC.
- R8: A 3-bit s-index i maps to x(8+i) for i < 2 and to x(16+i) otherwise. The index in bits 9:7 pairs with a0 (x10) and the index in bits 4:2 pairs with a1 (x11), and the copy runs in the direction set by bits 6:5.
- R9: One transfer is offered at a time. While mem_ready is low, the address, direction and store data stay unchanged.
- R10: done is a one-cycle pulse in the cycle after the last register-file or PC write. A start that arrives while an instruction is in progress is ignored.
- R11: During and after reset the block is idle, with done, mem_valid, rf_we and pc_we all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin executing instr (sampled when idle) |
| instr | input | 16 | Compressed instruction |
| done | output | 1 | Completion pulse |
| rf_raddr | output | 5 | Register-file read address |
| rf_rdata | input | W | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write address |
| rf_wdata | output | W | Register-file write data |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a store |
| mem_addr | output | W | Byte address |
| mem_wdata | output | W | Store data |
| mem_rdata | input | W | Load data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts the request |
| pc_we | output | 1 | Program-counter write enable |
| pc_wdata | output | W | New program counter |

## Verification
In the pop-return forms, the stack-pointer writeback and the program-counter update happen in the same cycle, and the PC value must be the x1 loaded in the preceding transfer. The bench runs pop-return and pop-return-zero, with and without memory stalls, and records the last cycle carrying a register or PC write. It then judges the stack pointer, the PC value and the register contents against an independent model, and checks that done comes exactly one cycle after that last write.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [15:0]  instr,
  output logic         done,
  output logic [4:0]   rf_raddr,
  input  logic [W-1:0] rf_rdata,
  output logic         rf_we,
  output logic [4:0]   rf_waddr,
  output logic [W-1:0] rf_wdata,
  output logic         mem_valid,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_ready,
  output logic         pc_we,
  output logic [W-1:0] pc_wdata
);

  typedef enum logic [2:0] {S_IDLE, S_SP, S_XFER, S_SPWR, S_ZERO, S_MV1, S_MV2, S_DONE} st_t;

  st_t         state;
  logic [15:0] ins_q;
  logic [3:0]  idx_q;
  logic [W-1:0] addr_q, sp_q, ra_q;

  function automatic logic [4:0] slot_reg(input logic [3:0] k);
    if (k == 4'd0)      return 5'd1;
    else if (k < 4'd3)  return 5'd7 + {1'b0, k};
    else                return 5'd15 + {1'b0, k};
  endfunction

  function automatic logic [4:0] s_reg(input logic [2:0] i);
    return (i < 3'd2) ? 5'd8 + {2'b0, i} : 5'd16 + {2'b0, i};
  endfunction

  wire [15:0] ins    = (state == S_IDLE) ? instr : ins_q;
  wire [7:0]  hi     = ins[15:8];
  wire        is_c   = ins[1:0] == 2'b10;
  wire        rl_ok  = ins[7:4] >= 4'd4;
  wire        op_push = is_c && rl_ok && hi == 8'hB8;
  wire        op_pop  = is_c && rl_ok && (hi == 8'hBA || hi == 8'hBC || hi == 8'hBE);
  wire        op_ret  = hi == 8'hBC || hi == 8'hBE;
  wire        op_zero = hi == 8'hBC;
  wire        op_mv   = is_c && ins[15:10] == 6'b101011 && ins[5];
  wire        to_a    = ins[6];
  wire [4:0]  sa      = s_reg(ins[9:7]);
  wire [4:0]  sb      = s_reg(ins[4:2]);
  wire [3:0]  nregs   = (ins[7:4] == 4'd15) ? 4'd13 : ins[7:4] - 4'd3;

  logic [7:0] adj8;
  always_comb begin
    if (nregs <= 4'd4)       adj8 = 8'd16;
    else if (nregs <= 4'd8)  adj8 = 8'd32;
    else if (nregs <= 4'd12) adj8 = 8'd48;
    else                     adj8 = 8'd64;
    adj8 = adj8 + {2'b0, ins[3:2], 4'b0};
  end
  wire [W-1:0] adj     = {{(W-8){1'b0}}, adj8};
  wire [4:0]   cur_reg = slot_reg(idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ins_q  <= '0;
      idx_q  <= '0;
      addr_q <= '0;
      sp_q   <= '0;
      ra_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          ins_q <= instr;
          state <= (op_push || op_pop) ? S_SP : op_mv ? S_MV1 : S_DONE;
        end
        S_SP: begin
          sp_q   <= rf_rdata;
          addr_q <= (op_push ? rf_rdata : rf_rdata + adj) - W'(4);
          idx_q  <= nregs - 4'd1;
          state  <= S_XFER;
        end
        S_XFER: if (mem_ready) begin
          if (op_pop && idx_q == 4'd0) ra_q <= mem_rdata;
          if (idx_q == 4'd0) state <= S_SPWR;
          else begin
            idx_q  <= idx_q - 4'd1;
            addr_q <= addr_q - W'(4);
          end
        end
        S_SPWR: state <= (op_ret && op_zero) ? S_ZERO : S_DONE;
        S_ZERO: state <= S_DONE;
        S_MV1:  state <= S_MV2;
        S_MV2:  state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rf_raddr = 5'd0;
    rf_we    = 1'b0;
    rf_waddr = 5'd0;
    rf_wdata = '0;
    case (state)
      S_SP:   rf_raddr = 5'd2;
      S_XFER: begin
        rf_raddr = cur_reg;
        rf_we    = op_pop && mem_ready;
        rf_waddr = cur_reg;
        rf_wdata = mem_rdata;
      end
      S_SPWR: begin
        rf_we    = 1'b1;
        rf_waddr = 5'd2;
        rf_wdata = op_push ? sp_q - adj : sp_q + adj;
      end
      S_ZERO: begin
        rf_we    = 1'b1;
        rf_waddr = 5'd10;
      end
      S_MV1: begin
        rf_raddr = to_a ? sa : 5'd10;
        rf_we    = 1'b1;
        rf_waddr = to_a ? 5'd10 : sa;
        rf_wdata = rf_rdata;
      end
      S_MV2: begin
        rf_raddr = to_a ? sb : 5'd11;
        rf_we    = 1'b1;
        rf_waddr = to_a ? 5'd11 : sb;
        rf_wdata = rf_rdata;
      end
      default: ;
    endcase
  end

  assign mem_valid = state == S_XFER;
  assign mem_we    = op_push;
  assign mem_addr  = addr_q;
  assign mem_wdata = rf_rdata;
  assign pc_we     = state == S_SPWR && op_ret;
  assign pc_wdata  = ra_q;
  assign done      = state == S_DONE;

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && idx_q != 4'd0 |=> mem_valid && mem_addr == $past(mem_addr) - W'(4));
  a_r7_pc_with_sp: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> rf_we && rf_waddr == 5'd2);
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_valid && !rf_we && !pc_we);
  a_r1_no_x0: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_waddr != 5'd0);

endmodule

// File: tb/sim_stack_seq.sv
module sim_stack_seq;
  logic clk = 0, rst_n = 0, start = 0, mem_ready = 1, stall_en = 0;
  logic [15:0] instr = 0;
  logic done, rf_we, mem_valid, mem_we, pc_we;
  logic [4:0] rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata, mem_addr, mem_wdata, mem_rdata, pc_wdata;

  always #2.5 clk = ~clk;

  stack_seq u0 (.clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .done(done),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .pc_we(pc_we), .pc_wdata(pc_wdata));

  logic [31:0] rf [32], mem [64], erf [32], emem [64];
  int tests = 0, fails = 0;
  int cyc = 0, last_wr = -1, done_cyc = -1, done_cnt = 0, acc_cnt = 0, pc_cnt = 0;
  logic [31:0] first_addr, pc_seen;

  localparam int ORD [13] = '{1, 8, 9, 18, 19, 20, 21, 22, 23, 24, 25, 26, 27};
  localparam int SMAP [8] = '{8, 9, 18, 19, 20, 21, 22, 23};
  localparam int NV = 12;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 16'hB842}, {1'b1, 16'hB8FE}, {1'b0, 16'hB886}, {1'b1, 16'hB8B2},
    {1'b0, 16'hBA5A}, {1'b1, 16'hBAF2}, {1'b0, 16'hBE66}, {1'b1, 16'hBEFE},
    {1'b1, 16'hBCC2}, {1'b0, 16'hBC42}, {1'b0, 16'hACB6}, {1'b0, 16'hAFE2}};

  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mem[mem_addr[7:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rf_we && rf_waddr != 0) rf[rf_waddr] <= rf_wdata;
    if (rf_we || pc_we) last_wr <= cyc;
    if (pc_we) begin pc_seen <= pc_wdata; pc_cnt <= pc_cnt + 1; end
    if (done) begin done_cyc <= cyc; done_cnt <= done_cnt + 1; end
    if (mem_valid && mem_ready) begin
      if (acc_cnt == 0) first_addr <= mem_addr;
      acc_cnt <= acc_cnt + 1;
      if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    end
  end
  always @(negedge clk) mem_ready <= stall_en ? ~mem_ready : 1'b1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  int e_n, e_first, e_ret, e_mem, e_valid;
  logic [31:0] e_pc;

  task automatic model(input logic [15:0] ins, input logic [31:0] sp);
    int n, adj, a;
    logic [7:0] h;
    h = ins[15:8];
    e_n = 0; e_ret = 0; e_mem = 0; e_valid = 1; e_first = 0;
    n = (ins[7:4] == 4'hF) ? 13 : int'(ins[7:4]) - 3;
    adj = ((n + 3) / 4) * 16 + 16 * int'(ins[3:2]);
    if (ins[1:0] == 2'b10 && ins[7:4] >= 4 && h == 8'hB8) begin
      e_mem = 1; e_n = n; a = sp; e_first = sp - 4;
      for (int j = 0; j < n; j++) begin a -= 4; emem[a[7:2]] = erf[ORD[n-1-j]]; end
      erf[2] = sp - adj;
    end else if (ins[1:0] == 2'b10 && ins[7:4] >= 4 && (h == 8'hBA || h == 8'hBC || h == 8'hBE)) begin
      e_mem = 1; e_n = n; a = sp + adj; e_first = a - 4;
      for (int j = 0; j < n; j++) begin a -= 4; erf[ORD[n-1-j]] = emem[a[7:2]]; end
      erf[2] = sp + adj;
      if (h != 8'hBA) begin e_ret = 1; e_pc = erf[1]; end
      if (h == 8'hBC) erf[10] = 0;
    end else if (ins[1:0] == 2'b10 && ins[15:10] == 6'b101011 && ins[6:5] == 2'b01) begin
      erf[SMAP[ins[9:7]]] = erf[10]; erf[SMAP[ins[4:2]]] = erf[11];
    end else if (ins[1:0] == 2'b10 && ins[15:10] == 6'b101011 && ins[6:5] == 2'b11) begin
      erf[10] = erf[SMAP[ins[9:7]]]; erf[11] = erf[SMAP[ins[4:2]]];
    end else e_valid = 0;
  endtask

  task automatic run(input logic [15:0] ins, input bit stall, input bit poke, input string tag);
    logic [31:0] sp;
    int t, bad;
    sp = (ins[15:8] == 8'hB8) ? 32'hC0 : 32'h30;
    for (int i = 0; i < 32; i++) rf[i] = (i == 0) ? 0 : 32'hC0DE_0000 | (i << 8) | i;
    rf[2] = sp;
    for (int i = 0; i < 64; i++) mem[i] = 32'h3300_0000 + i * 32'h0101;
    for (int i = 0; i < 32; i++) erf[i] = rf[i];
    for (int i = 0; i < 64; i++) emem[i] = mem[i];
    model(ins, sp);
    stall_en = stall;
    acc_cnt = 0; pc_cnt = 0; done_cnt = 0; last_wr = -1; done_cyc = -1;
    @(negedge clk); start = 1; instr = ins;
    @(negedge clk); start = 0;
    t = 0;
    while (!done && t < 400) begin
      if (poke && t == 2) begin start = 1; instr = 16'hBAF2; end
      else start = 0;
      @(negedge clk); t++;
    end
    start = 0;
    chk(done == 1, {tag, " R10 done"}, done, 1);
    repeat (6) @(negedge clk);
    stall_en = 0;
    chk(done_cnt == 1, {tag, " R10 single done"}, done_cnt, 1);
    if (e_valid) chk(done_cyc == last_wr + 1, {tag, " R10 done after last write"}, done_cyc, last_wr + 1);
    chk(acc_cnt == e_n, {tag, " R2 transfer count"}, acc_cnt, e_n);
    if (e_mem) chk(first_addr == e_first, {tag, " R3 first address"}, first_addr, e_first);
    chk(rf[2] == erf[2], {tag, " R4 sp"}, rf[2], erf[2]);
    bad = 0;
    for (int i = 0; i < 32; i++) if (rf[i] !== erf[i]) bad = i;
    chk(bad == 0, {tag, " R6 R8 registers"}, rf[bad], erf[bad]);
    bad = -1;
    for (int i = 0; i < 64; i++) if (mem[i] !== emem[i]) bad = i;
    chk(bad < 0, {tag, " R5 memory"}, bad, -1);
    chk(pc_cnt == e_ret, {tag, " R7 pc writes"}, pc_cnt, e_ret);
    if (e_ret) chk(pc_seen == e_pc, {tag, " R7 pc value"}, pc_seen, e_pc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !mem_valid && !rf_we && !pc_we, "R11 in reset", {done, mem_valid, rf_we, pc_we}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !mem_valid && !rf_we && !pc_we, "R11 after reset", {done, mem_valid, rf_we, pc_we}, 0);
    for (int v = 0; v < NV; v++) run(VEC[v][15:0], VEC[v][16], 1'b0, $sformatf("vec%0d", v));
    run(16'hB8FE, 1'b1, 1'b1, "R10 busy start");
    run(16'hB832, 1'b0, 1'b0, "R1 reserved list");
    run(16'hBA32, 1'b1, 1'b0, "R1 reserved pop");
    run(16'h0001, 1'b0, 1'b0, "R1 unknown");
    run(16'hADAA, 1'b0, 1'b0, "R8 mapping");
    run(16'hBEF2, 1'b1, 1'b0, "R7 R9 full popret stalled");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule